// File: doc/BRIEF.md
# Core Special I/O Register Bank

This block keeps the processor core's own special registers, which sit in the top eight ports of the 64-port I/O space, and serves byte-wide IN/OUT accesses to them. The registers are four address-extension page registers (for the D, X, Y and Z pointer paths), an extension register for indirect jumps, the two bytes of the stack pointer and the status register. Any port below the special window is forwarded unchanged to an external I/O bus, with the read data coming back from that bus.

Page registers are kept already shifted into bits 23:16 of a 24-bit value, so the address path can use them as the high address byte without a shifter. Build parameters say which of the four page registers exist and whether the stack pointer is 8 or 16 bits wide. Writes to a page register that does not exist, and to the stack pointer high byte on an 8-bit build, are dropped. The interrupt sequencer updates the stack pointer through its own decrement and load inputs.

The access interface is a plain strobe interface with no back-pressure. A read or write completes in the cycle in which its strobe is high, and there is no valid/ready handshake.

Top module: `sio_bank`

## Requirements
- R1: With `io_rd` high, the read data follows the port address: 0x38 page D, 0x39 page X, 0x3A page Y, 0x3B page Z, 0x3C jump extension, 0x3D stack pointer bits 7:0, 0x3E stack pointer bits 15:8, 0x3F status register.
- R2: Each page register and the jump extension register drives its byte on bits 23:16 of its 24-bit output, and bits 15:0 are always zero. A read returns that byte.
- R3: `PAGE_EN` bit 0 enables page D, bit 1 page X, bit 2 page Y and bit 3 page Z. A write to a page whose bit is 0 is ignored, and that page always outputs and reads back zero.
- R4: A write to port 0x3C always updates the jump extension register, whatever the parameters.
- R5: A write to port 0x3D replaces stack pointer bits 7:0 and leaves bits 15:8 unchanged.
- R6: A write to port 0x3E replaces stack pointer bits 15:8 and keeps bits 7:0 only when `SP_WIDE` is 1. When `SP_WIDE` is 0 the write is ignored and bits 15:8 always read zero.
- R7: For ports 0x00–0x37, `ext_rd`/`ext_wr` copy `io_rd`/`io_wr`, `ext_addr` and `ext_wdata` copy the access, and the read data is `ext_rdata`. For ports 0x38–0x3F both external strobes stay low.
- R8: Reads are combinational in the same cycle. `io_rdata` is zero while `io_rd` is low. Writes take effect at the next rising clock edge.
- R9: `sp_dec` lowers the stack pointer by one with wrap-around, and `sp_load` loads `sp_load_val`, both within the configured width. `sp_load` wins over `sp_dec`. A write to port 0x3D or 0x3E in the same cycle wins over both and blocks them, even when the write itself is ignored.
- R10: While `rst_n` is low, every register is zero.
- R11: A write to port 0x3F sets the status register, which is visible on `sreg_o` and readable at 0x3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| ext_addr | output | 6 | External bus port address |
| ext_rd | output | 1 | External bus read strobe |
| ext_wr | output | 1 | External bus write strobe |
| ext_wdata | output | 8 | External bus write data |
| ext_rdata | input | 8 | External bus read data |
| sp_dec | input | 1 | Stack pointer decrement request |
| sp_load | input | 1 | Stack pointer load request |
| sp_load_val | input | 16 | Stack pointer load value |
| sp_o | output | 16 | Current stack pointer |
| sreg_o | output | 8 | Current status register |
| page_d_o | output | 24 | Page D register, byte in bits 23:16 |
| page_x_o | output | 24 | Page X register, byte in bits 23:16 |
| page_y_o | output | 24 | Page Y register, byte in bits 23:16 |
| page_z_o | output | 24 | Page Z register, byte in bits 23:16 |
| jmp_ext_o | output | 24 | Jump extension register, byte in bits 23:16 |

## Verification
The bench runs a default build with page X disabled and a 16-bit stack pointer next to an 8-bit build that has only page X. This exposes a design that hard-codes either feature choice, because it would accept a dropped write or lose the high byte. Directed cases drive the stack pointer down across 0x0100 and across zero on the narrow build, where a design that fails to mask would leak a borrow into the high byte. They also combine port writes with decrement or load requests, which catches a wrong priority as an extra decrement. Further cases probe the edges of the special window at 0x37 and 0x38, where an off-by-one decode would fire the external strobes or hide external data, and they read with the strobe low, where a design that does not gate the output would leak register contents.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int SP_W    = 16;
  localparam int EXT_W   = 24;
  localparam int N_PAGE  = 4;
  localparam int N_XREG  = N_PAGE + 1;
  localparam int N_SPEC  = 8;

  localparam logic [ADDR_W-1:0] WIN_BASE = 6'h38;
  localparam logic [2:0] SLOT_JMP  = 3'd4;
  localparam logic [2:0] SLOT_SPLO = 3'd5;
  localparam logic [2:0] SLOT_SPHI = 3'd6;
  localparam logic [2:0] SLOT_SREG = 3'd7;

  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/sio_decode.sv
module sio_decode
  import sio_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              in_window,
  output logic [N_SPEC-1:0] wr_sel,
  output logic              ext_rd,
  output logic              ext_wr
);
  localparam int SLOT_BITS = $clog2(N_SPEC);

  assign in_window = (addr[ADDR_W-1:SLOT_BITS] == WIN_BASE[ADDR_W-1:SLOT_BITS]);

  always_comb begin
    wr_sel = '0;
    if (in_window && wr)
      wr_sel[addr[SLOT_BITS-1:0]] = 1'b1;
  end

  assign ext_rd = rd && !in_window;
  assign ext_wr = wr && !in_window;
endmodule

// File: rtl/sio_page_reg.sv
module sio_page_reg
  import sio_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  byte_t            wdata,
  output logic [EXT_W-1:0] value_o,
  output byte_t            byte_o
);
  localparam int LOW_W = EXT_W - DATA_W;

  generate
    if (ENABLE) begin : g_present
      byte_t hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  hi_q <= '0;
        else if (we) hi_q <= wdata;
      end
      assign byte_o = hi_q;
    end else begin : g_absent
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, we, wdata};
      assign byte_o = '0;
    end
  endgenerate

  assign value_o = {byte_o, {LOW_W{1'b0}}};
endmodule

// File: rtl/sio_stack_ptr.sv
module sio_stack_ptr
  import sio_pkg::*;
#(
  parameter bit WIDE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  byte_t           wdata,
  input  logic            dec,
  input  logic            load,
  input  logic [SP_W-1:0] load_val,
  output logic [SP_W-1:0] sp_o
);
  localparam logic [SP_W-1:0] SP_MASK = WIDE ? {SP_W{1'b1}} : {{(SP_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

  logic [SP_W-1:0] sp_q, sp_d;

  always_comb begin
    sp_d = sp_q;
    if (wr_lo)
      sp_d = {sp_q[SP_W-1:DATA_W], wdata};
    else if (wr_hi) begin
      if (WIDE) sp_d = {wdata, sp_q[DATA_W-1:0]};
    end else if (load)
      sp_d = load_val & SP_MASK;
    else if (dec)
      sp_d = (sp_q - 1'b1) & SP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/sio_bank.sv
module sio_bank
  import sio_pkg::*;
#(
  parameter logic [3:0] PAGE_EN = 4'b1101,
  parameter bit         SP_WIDE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic [5:0]  ext_addr,
  output logic        ext_rd,
  output logic        ext_wr,
  output logic [7:0]  ext_wdata,
  input  logic [7:0]  ext_rdata,
  input  logic        sp_dec,
  input  logic        sp_load,
  input  logic [15:0] sp_load_val,
  output logic [15:0] sp_o,
  output logic [7:0]  sreg_o,
  output logic [23:0] page_d_o,
  output logic [23:0] page_x_o,
  output logic [23:0] page_y_o,
  output logic [23:0] page_z_o,
  output logic [23:0] jmp_ext_o
);
  localparam logic [N_XREG-1:0] XREG_EN = {1'b1, PAGE_EN};

  logic              in_window;
  logic [N_SPEC-1:0] wr_sel;
  logic [EXT_W-1:0]  xreg_val  [N_XREG];
  byte_t             spec_byte [N_SPEC];
  byte_t             sreg_q;

  sio_decode u_decode (
    .addr      (io_addr),
    .rd        (io_rd),
    .wr        (io_wr),
    .in_window (in_window),
    .wr_sel    (wr_sel),
    .ext_rd    (ext_rd),
    .ext_wr    (ext_wr)
  );

  generate
    for (genvar gi = 0; gi < N_XREG; gi++) begin : g_xreg
      sio_page_reg #(.ENABLE(XREG_EN[gi])) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_sel[gi]),
        .wdata   (io_wdata),
        .value_o (xreg_val[gi]),
        .byte_o  (spec_byte[gi])
      );
    end
  endgenerate

  sio_stack_ptr #(.WIDE(SP_WIDE)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_sel[SLOT_SPLO]),
    .wr_hi    (wr_sel[SLOT_SPHI]),
    .wdata    (io_wdata),
    .dec      (sp_dec),
    .load     (sp_load),
    .load_val (sp_load_val),
    .sp_o     (sp_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sreg_q <= '0;
    else if (wr_sel[SLOT_SREG]) sreg_q <= io_wdata;
  end

  assign spec_byte[SLOT_SPLO] = sp_o[DATA_W-1:0];
  assign spec_byte[SLOT_SPHI] = sp_o[SP_W-1:DATA_W];
  assign spec_byte[SLOT_SREG] = sreg_q;

  always_comb begin
    io_rdata = '0;
    if (io_rd)
      io_rdata = in_window ? spec_byte[io_addr[2:0]] : ext_rdata;
  end

  assign ext_addr  = io_addr;
  assign ext_wdata = io_wdata;
  assign sreg_o    = sreg_q;
  assign page_d_o  = xreg_val[0];
  assign page_x_o  = xreg_val[1];
  assign page_y_o  = xreg_val[2];
  assign page_z_o  = xreg_val[3];
  assign jmp_ext_o = xreg_val[SLOT_JMP];
endmodule

// File: rtl/sio_bank_chk.sv
module sio_bank_chk #(
  parameter logic [3:0] PAGE_EN = 4'b1101,
  parameter bit         SP_WIDE = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic        ext_rd,
  input logic        ext_wr,
  input logic        sp_dec,
  input logic        sp_load,
  input logic [15:0] sp_load_val,
  input logic [15:0] sp_o,
  input logic [7:0]  sreg_o,
  input logic [23:0] page_x_o,
  input logic [23:0] page_z_o,
  input logic [23:0] jmp_ext_o
);
  localparam logic [15:0] MASK = SP_WIDE ? 16'hFFFF : 16'h00FF;

  logic sp_port_wr;
  assign sp_port_wr = io_wr && (io_addr == 6'h3D || io_addr == 6'h3E);

  AST_EXT_WR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr |-> (io_wr && io_addr < 6'h38)); // R7
  AST_EXT_RD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd |-> (io_rd && io_addr < 6'h38)); // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00); // R8
  AST_JMP_ALWAYS_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 6'h3C) |=> jmp_ext_o[23:16] == $past(io_wdata)); // R4
  AST_SPLO_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 6'h3D) |=> sp_o[15:8] == $past(sp_o[15:8])); // R5
  AST_SPHI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 6'h3E) |=> sp_o[7:0] == $past(sp_o[7:0])); // R6
  AST_SP_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !SP_WIDE |-> sp_o[15:8] == 8'h00); // R6
  AST_SP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_load && !sp_port_wr) |=> sp_o == ($past(sp_load_val) & MASK)); // R9
  AST_SP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_dec && !sp_load && !sp_port_wr) |=> sp_o == (($past(sp_o) - 16'd1) & MASK)); // R9
  AST_SREG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 6'h3F) |=> sreg_o == $past(io_wdata)); // R11
  AST_PAGE_X_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    !PAGE_EN[1] |-> page_x_o == 24'h0); // R3
  AST_PAGE_Z_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    page_z_o[15:0] == 16'h0); // R2
endmodule

bind sio_bank sio_bank_chk #(.PAGE_EN(PAGE_EN), .SP_WIDE(SP_WIDE)) u_chk (.*);

// File: tb/sio_bank_tb.sv
module sio_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0, ext_rdata = '0;
  logic        sp_dec = 1'b0, sp_load = 1'b0;
  logic [15:0] sp_load_val = '0;

  logic [7:0]  rdata [2];
  logic [5:0]  eaddr [2];
  logic        erd [2], ewr [2];
  logic [7:0]  ewd [2];
  logic [15:0] sp [2];
  logic [7:0]  sreg [2];
  logic [23:0] pg [2][4];
  logic [23:0] jx [2];

  int nvec = 0, nfail = 0;
  bit done = 0;

  // model configuration: instance 0 default, instance 1 narrow SP with only page X
  bit [3:0] cfg_pen [2] = '{4'b1101, 4'b0010};
  bit       cfg_wide [2] = '{1'b1, 1'b0};
  int m_page [2][4];
  int m_jmp [2], m_sp [2], m_sreg [2];

  always #10 clk = ~clk;

  sio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(rdata[0]), .ext_addr(eaddr[0]), .ext_rd(erd[0]),
    .ext_wr(ewr[0]), .ext_wdata(ewd[0]), .ext_rdata(ext_rdata), .sp_dec(sp_dec),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .sp_o(sp[0]), .sreg_o(sreg[0]),
    .page_d_o(pg[0][0]), .page_x_o(pg[0][1]), .page_y_o(pg[0][2]), .page_z_o(pg[0][3]),
    .jmp_ext_o(jx[0])
  );

  sio_bank #(.PAGE_EN(4'b0010), .SP_WIDE(1'b0)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(rdata[1]), .ext_addr(eaddr[1]), .ext_rd(erd[1]),
    .ext_wr(ewr[1]), .ext_wdata(ewd[1]), .ext_rdata(ext_rdata), .sp_dec(sp_dec),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .sp_o(sp[1]), .sreg_o(sreg[1]),
    .page_d_o(pg[1][0]), .page_x_o(pg[1][1]), .page_y_o(pg[1][2]), .page_z_o(pg[1][3]),
    .jmp_ext_o(jx[1])
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_read(int k);
    int a = io_addr;
    if (!io_rd) return 0;
    if (a < 'h38) return ext_rdata;
    if (a < 'h3C) return m_page[k][a - 'h38];
    if (a == 'h3C) return m_jmp[k];
    if (a == 'h3D) return m_sp[k] & 'hFF;
    if (a == 'h3E) return m_sp[k] >> 8;
    return m_sreg[k];
  endfunction

  task automatic model_update(int k);
    int a = io_addr;
    int mask = cfg_wide[k] ? 'hFFFF : 'hFF;
    if (io_wr && a >= 'h38 && a <= 'h3B && cfg_pen[k][a - 'h38]) m_page[k][a - 'h38] = io_wdata;
    if (io_wr && a == 'h3C) m_jmp[k] = io_wdata;
    if (io_wr && a == 'h3F) m_sreg[k] = io_wdata;
    if (io_wr && a == 'h3D)      m_sp[k] = (m_sp[k] & 'hFF00) | io_wdata;
    else if (io_wr && a == 'h3E) begin
      if (cfg_wide[k]) m_sp[k] = (m_sp[k] & 'hFF) | (int'(io_wdata) << 8);
    end
    else if (sp_load) m_sp[k] = sp_load_val & mask;
    else if (sp_dec)  m_sp[k] = (m_sp[k] - 1) & mask;
  endtask

  // compare every output against the model, then advance one clock
  task automatic cycle();
    #5;
    for (int k = 0; k < 2; k++) begin
      bit internal = (io_addr >= 6'h38);
      string pre = rst_n ? "" : "R10 ";
      chk({pre, "R1/R8 io_rdata"}, rdata[k], exp_read(k));
      chk({pre, "R7 ext_rd"}, erd[k], io_rd && !internal);
      chk({pre, "R7 ext_wr"}, ewr[k], io_wr && !internal);
      chk({pre, "R7 ext_addr"}, eaddr[k], io_addr);
      chk({pre, "R7 ext_wdata"}, ewd[k], io_wdata);
      chk({pre, "R5/R6/R9 sp"}, sp[k], m_sp[k]);
      chk({pre, "R11 status"}, sreg[k], m_sreg[k]);
      chk({pre, "R4 jump ext"}, jx[k], m_jmp[k] << 16);
      for (int p = 0; p < 4; p++) chk({pre, "R2/R3 page"}, pg[k][p], m_page[k][p] << 16);
    end
    if (rst_n) begin
      model_update(0);
      model_update(1);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [5:0] a, input logic rd, input logic wr, input logic [7:0] wd,
                       input logic dec = 0, input logic ld = 0, input logic [15:0] lv = 0);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = wd;
    sp_dec = dec; sp_load = ld; sp_load_val = lv;
    cycle();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_jmp[k] = 0; m_sp[k] = 0; m_sreg[k] = 0;
      for (int p = 0; p < 4; p++) m_page[k][p] = 0;
    end
    // R10: reset state, with write attempts that must not land
    @(negedge clk);
    drive(6'h3F, 1, 1, 8'hAA);
    drive(6'h3D, 1, 1, 8'h55, 1);
    rst_n = 1'b1;
    // R1 R3 R4 R5 R6 R11: write every special port, then read each back
    for (int a = 'h38; a <= 'h3F; a++) drive(6'(a), 0, 1, 8'(8'h90 + a));
    for (int a = 'h38; a <= 'h3F; a++) drive(6'(a), 1, 0, 8'h00);
    // R8: read strobe low on an internal port gives zero
    drive(6'h3F, 0, 0, 8'h00);
    // R5: low byte write keeps the high byte
    drive(6'h3E, 0, 1, 8'h12);
    drive(6'h3D, 1, 1, 8'h34);
    drive(6'h3E, 1, 0, 8'h00);
    // R9: decrement across a byte boundary, and narrow wrap through zero
    drive(6'h00, 0, 0, 8'h00, 0, 1, 16'h0100);
    drive(6'h00, 0, 0, 8'h00, 1);
    drive(6'h00, 0, 0, 8'h00, 1);
    // R9: load beats decrement
    drive(6'h00, 0, 0, 8'h00, 1, 1, 16'hBEEF);
    // R9: port write beats load and decrement, including the ignored high write on narrow
    drive(6'h3D, 0, 1, 8'h77, 1, 1, 16'h4242);
    drive(6'h3E, 0, 1, 8'h66, 1, 1, 16'h4242);
    drive(6'h3E, 1, 0, 8'h00);
    // R7: external window edges
    ext_rdata = 8'hA5;
    drive(6'h37, 1, 0, 8'h00);
    drive(6'h37, 0, 1, 8'h3C);
    drive(6'h00, 1, 1, 8'h11);
    drive(6'h38, 1, 0, 8'h00);
    // R2 R3: disabled page writes dropped
    drive(6'h39, 0, 1, 8'hC3);
    drive(6'h38, 0, 1, 8'hD4);
    drive(6'h39, 1, 0, 8'h00);
    drive(6'h38, 1, 0, 8'h00);
    // mixed traffic around the special window
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom;
      logic [5:0] a = (r[3:0] < 4'd12) ? 6'(6'h36 + r[7:4] % 10) : 6'(r[9:4]);
      ext_rdata = 8'($urandom);
      drive(a, r[16], r[17], 8'($urandom), r[18] & r[19], r[20] & r[21] & r[22], 16'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule